// File: doc/BRIEF.md
# Streaming Positional Popcount Unit

This block keeps eight running totals over a stream of bytes. Total j is the number of input bytes that have bit j set. To begin a job, software or an upstream engine pulses `start` together with a byte count. The unit then takes exactly that many bytes over a valid/ready stream and raises `done` for one cycle once the totals are final.

Bytes are collected into an 8-lane block register. The register is cleared before each block is filled. When a block holds eight bytes, or holds the last byte of the job, the unit spends one cycle on three steps. It flips the 8x8 bit matrix, so that bit j of lane i becomes bit i of row j. It counts the ones in each of the eight rows. It adds row j's count into total j. A short final block keeps zeros in its unfilled lanes, so it adds nothing extra. The remaining count drops by eight per block, and the job ends once it is zero or negative.

Top module: `pos_popcount`

## Requirements
- R1: After reset, `done` and `in_ready` are 0 and all eight totals are 0.
- R2: A `start` accepted while idle clears all eight totals in the next cycle. For a nonzero `length`, `in_ready` is 1 in that same next cycle.
- R3: Lane j of `count` (bits 32*j+31..32*j) ends equal to the number of accepted bytes whose bit j (bit 0 = LSB) is 1. After each block, the totals equal this sum over all bytes accepted so far.
- R4: After the 8th byte of a block, or after the final byte of the job, is accepted, `in_ready` is 0 for exactly the next cycle. The totals show that block's contribution in the cycle after that.
- R5: Exactly `length` bytes are accepted. Unfilled lanes of a short final block are zero and add nothing to any total.
- R6: `done` is high for exactly one cycle. It rises in the same cycle that the totals first include the final block.
- R7: A `start` with `length` = 0 raises `done` in the next cycle. All totals are then 0, and `in_ready` never rises for that job.
- R8: A `start` that arrives while a job is in progress is ignored. The running job's totals and byte count are unaffected.
- R9: After `done`, the totals hold their values until the next accepted `start`.
- R10: A single block update raises any total by at most 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (taken only while idle) |
| length | input | 32 | Number of bytes in the job |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Unit can take a byte this cycle |
| in_data | input | 8 | Input byte |
| done | output | 1 | One-cycle pulse: totals are final |
| count | output | 8x32 | Packed totals; lane j at bits 32*j+31..32*j |

## Verification
The bench targets four cases:
- Lengths at and around block edges (1, 7, 8, 9, 16). A design that ignored zero-padding, or counted the wrong number of lanes, would take one byte too many or too few, or would fold stale lanes into the totals.
- A zero length. A broken design would hang or open `in_ready`.
- A second `start` during a busy job. A design that honoured it would restart the totals or change the byte budget.
- Random data with random `in_valid` gaps. The totals are compared after every block, not only at the end. This exposes a transposition with swapped indices, because that sends counts to the wrong lane.

// File: rtl/pos_popcount.sv
module pos_popcount #(
  parameter int CNT_W = 32,
  parameter int LEN_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [LEN_W-1:0]           length,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [7:0]                 in_data,
  output logic                       done,
  output logic [7:0][CNT_W-1:0]      count
);
  localparam int LANES = 8;
  localparam int REM_W = LEN_W + 1;
  localparam logic signed [REM_W-1:0] BLK = REM_W'(LANES);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SUM} st_t;

  st_t                      st;
  logic signed [REM_W-1:0]  rem;
  logic [2:0]               idx;
  logic [LANES-1:0][7:0]    blk;
  logic [LANES-1:0][7:0]    flip;
  logic [LANES-1:0][CNT_W-1:0] acc;
  logic [3:0]               fill;
  logic                     last_lane;

  function automatic logic [3:0] ones8(input logic [7:0] b);
    logic [3:0] s;
    s = '0;
    for (int k = 0; k < 8; k++) s = s + 4'(b[k]);
    return s;
  endfunction

  always_comb begin
    for (int r = 0; r < LANES; r++)
      for (int c = 0; c < LANES; c++)
        flip[r][c] = blk[c][r];
  end

  assign fill      = (rem >= BLK) ? 4'd8 : rem[3:0];
  assign last_lane = ({1'b0, idx} + 4'd1) == fill;
  assign in_ready  = (st == S_LOAD);
  assign count     = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rem  <= '0;
      idx  <= '0;
      blk  <= '0;
      acc  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          acc <= '0;
          blk <= '0;
          idx <= '0;
          rem <= $signed({1'b0, length});
          if (length == '0) done <= 1'b1;
          else              st   <= S_LOAD;
        end
        S_LOAD: if (in_valid) begin
          blk[idx] <= in_data;
          idx      <= idx + 3'd1;
          if (last_lane) st <= S_SUM;
        end
        default: begin
          for (int j = 0; j < LANES; j++)
            acc[j] <= acc[j] + CNT_W'(ones8(flip[j]));
          rem <= rem - BLK;
          blk <= '0;
          idx <= '0;
          if (rem <= BLK) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_LOAD;
          end
        end
      endcase
    end
  end

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (count == '0));

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && length == '0) |=> (done && !in_ready));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  // R5
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && idx == 3'd0) |-> (blk == '0));

  // R4
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && in_valid && last_lane) |=> !in_ready);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && start) |=> $stable(rem));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // R10
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_SUM) |=> ((count[g] - $past(count[g])) <= CNT_W'(8)));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_SUM && !(st == S_IDLE && start)) |=> $stable(count[g]));
  end
endmodule

// File: tb/test_pos_popcount.sv
module test_pos_popcount;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] length = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic done;
  logic [7:0][31:0] count;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] mem [0:255];

  always #2 clk = ~clk;

  pos_popcount i_pos_popcount (
    .clk(clk), .rst_n(rst_n), .start(start), .length(length),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .done(done), .count(count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cnt(input int j, input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += int'(mem[i][j]);
    return s;
  endfunction

  task automatic check_totals(input string req, input int n);
    for (int j = 0; j < 8; j++)
      chk(count[j] == 32'(exp_cnt(j, n)), req, int'(count[j]), exp_cnt(j, n));
  endtask

  // at a negedge: run one job of len bytes
  task automatic run(input int len, input bit gaps, input bit busy_start);
    int k = 0;
    int phase = 0;
    int guard = 0;
    bit fired = 0;
    bit seen = 0;
    start = 1'b1; length = 32'(len);
    @(negedge clk);
    start = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R7 done", int'(done), 1);
      chk(in_ready == 1'b0, "R7 ready", int'(in_ready), 0);
      check_totals("R7 totals", 0);
      @(negedge clk);
      chk(done == 1'b0, "R6 pulse", int'(done), 0);
      chk(in_ready == 1'b0, "R7 ready after", int'(in_ready), 0);
      return;
    end
    check_totals("R2 clear", 0);
    chk(in_ready == 1'b1, "R2 ready", int'(in_ready), 1);
    while (!seen && guard < 4000) begin
      guard++;
      start = 1'b0;
      if (phase == 2) begin
        check_totals("R3 block totals", k);
        if (k == len) begin
          chk(done == 1'b1, "R6 done", int'(done), 1);
          seen = 1;
        end else begin
          chk(done == 1'b0, "R6 early", int'(done), 0);
        end
        phase = 0;
      end
      if (phase == 1) begin
        chk(in_ready == 1'b0, "R4 gap", int'(in_ready), 0);
        phase = 2;
      end
      if (seen) break;
      in_valid = (k < len) && (gaps ? ($urandom % 4 != 0) : 1'b1);
      in_data  = mem[k];
      if (busy_start && !fired && k == 3) begin
        start = 1'b1; length = 32'd5; fired = 1;
      end
      if (in_valid && in_ready) begin
        k++;
        if (k % 8 == 0 || k == len) phase = 1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    start = 1'b0;
    chk(seen, "R6 reached", int'(seen), 1);
    chk(k == len, "R5 byte count", k, len);
    @(negedge clk);
    chk(done == 1'b0, "R6 pulse", int'(done), 0);
    in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R5 no extra", int'(in_ready), 0);
    in_valid = 1'b0;
    check_totals("R9 hold", len);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);
    check_totals("R1 totals", 0);
    @(negedge clk);

    run(0, 0, 0);
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    run(8, 0, 0);
    mem[0] = 8'h80;
    run(1, 0, 0);
    for (int i = 0; i < 256; i++) mem[i] = 8'(1 << (i % 8));
    run(7, 1, 0);
    run(9, 0, 0);
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    run(16, 1, 0);
    run(20, 1, 1);
    run(37, 1, 0);
    run(100, 1, 0);
    run(253, 0, 0);
    run(0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule